// File: doc/BRIEF.md
# Back Porch Gate Generator

This block watches an active-low composite sync signal that is synchronous to nothing in particular. It raises a low-going gate over the colour-burst / back-porch region that follows every sync pulse. Each trailing (rising) edge of `sync_n` starts a short wait. When the wait ends, `porch_n` goes low for a fixed width. Serration pulses inside the vertical interval have rising edges too, so each of them produces its own gate.

The wait and the width are multiples of two base cycle counts, and one shared timing-scale code stretches both. With a 125 MHz clock the defaults give 25 cycles (200 ns) of wait and 437 cycles (3.5 µs) of gate per scale step. The block applies scale multiplier `tscale + 1`.

Internally, a two-flop synchroniser and an edge detector feed a three-state controller:
- `PG_IDLE`: the gate is high and no edge is pending.
- `PG_WAIT`: the delay counter is running.
- `PG_GATE`: `porch_n` is low while the width counter runs.

The controller has four named transitions:
- T_START: `PG_IDLE` to `PG_WAIT` on a detected rise.
- T_OPEN: `PG_WAIT` to `PG_GATE` when the delay count expires.
- T_CLOSE: `PG_GATE` to `PG_IDLE` when the width count expires.
- T_RESTART: `PG_WAIT` or `PG_GATE` back to `PG_WAIT` on a new rise, which reloads the delay.

Top module: `porch_gate_gen`

## Requirements
- R1: `porch_n` is active low and rests high. While `rst_n` is low, `porch_n` is high at once and both counters are cleared. The synchroniser flops reset to the idle (high) sync level, so releasing reset with `sync_n` high produces no gate.
- R2: Only a rising edge of `sync_n` starts a gate. A falling edge of `sync_n` has no effect on `porch_n`.
- R3: With S = `tscale`, `porch_n` falls at the (DLY_BASE·(S+1)+3)-th rising clock edge, counting the first edge that samples `sync_n` high as edge 1. With the defaults this is edge 28 for S=0, 53 for S=1, 103 for S=3 and 203 for S=7.
- R4: `porch_n` stays low for exactly WID_BASE·(S+1) clock cycles. With the defaults this is 437, 874, 1748 and 3496 cycles for S = 0, 1, 3, 7.
- R5: The wait uses the `tscale` value present when the edge is detected, which is the third edge after `sync_n` is first sampled high. The width uses that same captured value. Changes to `tscale` after that point do not alter the pulse in progress.
- R6: A rising edge that arrives while a gate is pending or active restarts the delay. `porch_n` is high again after the third clock edge counted from the new edge, and then falls per R3 measured from the new edge.
- R7: Every rising edge triggers its own gate, including edges of serration pulses and sync-high intervals of only one clock cycle.
- R8: While `sync_n` stays low and no gate is in progress, `porch_n` stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (nominally 125 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low composite sync, asynchronous to `clk` |
| tscale | input | SCALE_W | Timing-scale code; delay and width are multiplied by `tscale + 1` |
| porch_n | output | 1 | Active-low back-porch gate |

## Verification
The gate falls 2 + DLY_BASE·(S+1) cycles after the edge that first samples the rising sync. Two of those cycles are the synchroniser, and the third edge is the one at which the controller enters `PG_WAIT`. After falling, the gate lasts WID_BASE·(S+1) cycles. A restart returns the gate high three edges after the new rise.

The bench changes `sync_n` only on falling clock edges and counts rising edges one by one from that change. It samples `porch_n` on the falling edge that follows each counted rising edge, so every measured latency and width is an exact cycle count compared against the figure given in the requirement.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_WAIT = 2'd1,
        PG_GATE = 2'd2
    } pg_state_e;

    function automatic int unsigned pg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pg_edge_sync.sv
module pg_edge_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= IDLE_LVL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{IDLE_LVL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IDLE_LVL;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pg_scale.sv
module pg_scale #(
    parameter int unsigned SCALE_W  = 3,
    parameter int unsigned DLY_BASE = 25,
    parameter int unsigned WID_BASE = 437,
    parameter int unsigned CNT_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [CNT_W-1:0]   dly_ld_o,
    output logic [CNT_W-1:0]   wid_ld_o
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] DLY_C = CNT_W'(DLY_BASE);
    localparam logic [CNT_W-1:0] WID_C = CNT_W'(WID_BASE);

    logic [SCALE_W-1:0] held_q;
    logic [CNT_W-1:0]   mult_now;
    logic [CNT_W-1:0]   mult_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         held_q <= '0;
        else if (capture_i) held_q <= scale_i;
    end

    assign mult_now  = CNT_W'(scale_i) + ONE;
    assign mult_held = CNT_W'(held_q) + ONE;

    // delay load uses the live code (taken on the trigger edge itself)
    assign dly_ld_o = DLY_C * mult_now - ONE;
    // width load uses the code captured on the trigger edge
    assign wid_ld_o = WID_C * mult_held - ONE;

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
    import pg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] dly_ld_i,
    input  logic [CNT_W-1:0] wid_ld_i,
    output logic             porch_n_o,
    output pg_state_e        state_o,
    output logic [CNT_W-1:0] cnt_o
);

    pg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_IDLE: begin
                if (rise_i) begin              // T_START
                    state_d = PG_WAIT;
                    cnt_d   = dly_ld_i;
                end
            end
            PG_WAIT: begin
                if (rise_i) begin              // T_RESTART
                    state_d = PG_WAIT;
                    cnt_d   = dly_ld_i;
                end else if (cnt_q == '0) begin // T_OPEN
                    state_d = PG_GATE;
                    cnt_d   = wid_ld_i;
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            PG_GATE: begin
                if (rise_i) begin              // T_RESTART
                    state_d = PG_WAIT;
                    cnt_d   = dly_ld_i;
                end else if (cnt_q == '0) begin // T_CLOSE
                    state_d = PG_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = PG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        porch_n_o = 1'b1;
        unique case (state_q)
            PG_GATE: porch_n_o = 1'b0;
            default: porch_n_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/porch_gate_gen.sv
module porch_gate_gen
    import pg_pkg::*;
#(
    parameter int unsigned DLY_BASE    = 25,
    parameter int unsigned WID_BASE    = 437,
    parameter int unsigned SCALE_W     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic [SCALE_W-1:0] tscale,
    output logic               porch_n
);

    localparam int unsigned MULT_MAX = 1 << SCALE_W;
    localparam int unsigned LONGEST  = pg_max(DLY_BASE, WID_BASE) * MULT_MAX;
    localparam int unsigned CNT_W    = $clog2(LONGEST + 1);

    logic             sync_rise;
    logic [CNT_W-1:0] dly_ld;
    logic [CNT_W-1:0] wid_ld;
    pg_state_e        fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    pg_edge_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (sync_n),
        .rise_o (sync_rise)
    );

    pg_scale #(
        .SCALE_W  (SCALE_W),
        .DLY_BASE (DLY_BASE),
        .WID_BASE (WID_BASE),
        .CNT_W    (CNT_W)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (sync_rise),
        .scale_i   (tscale),
        .dly_ld_o  (dly_ld),
        .wid_ld_o  (wid_ld)
    );

    pg_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (sync_rise),
        .dly_ld_i  (dly_ld),
        .wid_ld_i  (wid_ld),
        .porch_n_o (porch_n),
        .state_o   (fsm_state),
        .cnt_o     (fsm_cnt)
    );

endmodule

// File: rtl/pg_chk.sv
module pg_chk
    import pg_pkg::*;
#(
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned MAX_LOW = 3496
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_n,
    input logic             porch_n,
    input logic             rise,
    input pg_state_e        state,
    input logic [CNT_W-1:0] cnt
);

    localparam int unsigned RUN_W = $clog2(MAX_LOW + 1) + 1;

    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_run_q <= '0;
        else if (porch_n) low_run_q <= '0;
        else              low_run_q <= low_run_q + 1'b1;
    end

    // R4
    gate_width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !porch_n |-> (low_run_q < RUN_W'(MAX_LOW)));

    // R3
    gate_opens_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(porch_n) |-> ($past(state) == PG_WAIT));

    // R6
    restart_releases_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> ##3 porch_n);

    // R4
    gate_closes_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(porch_n) |-> (($past(cnt) == '0) || $past(rise)));

endmodule

bind porch_gate_gen pg_chk #(
    .CNT_W   (CNT_W),
    .MAX_LOW (WID_BASE * MULT_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .porch_n (porch_n),
    .rise    (sync_rise),
    .state   (fsm_state),
    .cnt     (fsm_cnt)
);

// File: tb/porch_gate_gen_tb.sv
`timescale 1ns/1ps
module porch_gate_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic [2:0] tscale = 3'd0;
    logic       porch_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    porch_gate_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .tscale  (tscale),
        .porch_n (porch_n)
    );

    // {scale, expected fall edge, expected low width}
    localparam int NVEC = 4;
    localparam int VEC [NVEC][3] = '{
        '{0,  28,  437},
        '{1,  53,  874},
        '{3, 103, 1748},
        '{7, 203, 3496}
    };

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic hold_low(input int n);
        @(negedge clk);
        sync_n = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic fire_measure(output int t_fall, output int t_low);
        @(negedge clk);
        sync_n = 1'b1;
        t_fall = 0;
        do begin
            @(posedge clk);
            t_fall++;
            @(negedge clk);
        end while (porch_n && t_fall < 5000);
        t_low = 0;
        while (!porch_n && t_low < 10000) begin
            @(posedge clk);
            @(negedge clk);
            t_low++;
        end
    endtask

    initial begin
        int tf, tl, lows, falls, n;
        logic prev;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 gate high in reset", int'(porch_n), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!porch_n) lows++;
        end
        chk("R1 no gate after reset release", lows, 0);

        // R3 / R4 vector table
        for (int v = 0; v < NVEC; v++) begin
            tscale = 3'(VEC[v][0]);
            hold_low(8);
            fire_measure(tf, tl);
            chk($sformatf("R3 delay scale %0d", VEC[v][0]), tf, VEC[v][1]);
            chk($sformatf("R4 width scale %0d", VEC[v][0]), tl, VEC[v][2]);
        end
        tscale = 3'd0;

        // R2 / R8: falling edge and long low do nothing
        hold_low(1);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!porch_n) lows++;
        end
        chk("R2 falling edge ignored", lows, 0);
        chk("R8 long low stays idle", int'(porch_n), 1);

        // R6: restart during delay
        @(negedge clk);
        sync_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 still pending before restart", int'(porch_n), 1);
        sync_n = 1'b0;
        repeat (3) @(negedge clk);
        fire_measure(tf, tl);
        chk("R6 delay restarted from new edge", tf, 28);
        chk("R6 width after restart", tl, 437);

        // R6: restart during active gate
        hold_low(8);
        @(negedge clk);
        sync_n = 1'b1;
        n = 0;
        while (porch_n && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        repeat (100) @(negedge clk);
        sync_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 falling edge during gate ignored", int'(porch_n), 0);
        sync_n = 1'b1;
        n = 0;
        while (!porch_n && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk("R6 gate released after restart", n, 3);
        while (porch_n && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk("R6 new delay after active restart", n, 28);
        tl = 0;
        while (!porch_n && tl < 10000) begin
            @(posedge clk);
            @(negedge clk);
            tl++;
        end
        chk("R6 new width after active restart", tl, 437);

        // R5: scale change after capture has no effect
        tscale = 3'd0;
        hold_low(8);
        @(negedge clk);
        sync_n = 1'b1;
        n = 0;
        while (porch_n && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 5) tscale = 3'd7;
        end
        chk("R5 delay uses captured scale", n, 28);
        tl = 0;
        while (!porch_n && tl < 10000) begin
            @(posedge clk);
            @(negedge clk);
            tl++;
            if (tl == 50) tscale = 3'd3;
        end
        chk("R5 width uses captured scale", tl, 437);
        tscale = 3'd0;

        // R7: serration-style train, one gate per rising edge
        hold_low(8);
        falls = 0;
        prev  = porch_n;
        for (int p = 0; p < 3; p++) begin
            sync_n = 1'b1;
            for (int c = 0; c < 560; c++) begin
                @(negedge clk);
                if (prev && !porch_n) falls++;
                prev = porch_n;
            end
            sync_n = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (prev && !porch_n) falls++;
                prev = porch_n;
            end
        end
        chk("R7 gates per serration train", falls, 3);

        // R7: one-cycle high pulse still triggers
        hold_low(8);
        sync_n = 1'b1;
        @(negedge clk);
        sync_n = 1'b0;
        tf = 1;
        while (porch_n && tf < 5000) begin
            @(posedge clk);
            @(negedge clk);
            tf++;
        end
        chk("R7 single-cycle pulse delay", tf, 28);

        // R1: reset in the middle of a gate
        repeat (50) @(negedge clk);
        chk("R1 gate low before reset", int'(porch_n), 0);
        sync_n = 1'b1;
        rst_n  = 1'b0;
        #1;
        chk("R1 reset forces gate high", int'(porch_n), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!porch_n) lows++;
        end
        chk("R1 cleared counters, no gate after reset", lows, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule